// File: doc/BRIEF.md
# Vector Element Address Generator

This block turns one vector memory command into the sequence of element addresses that a load or store unit needs. A command carries an addressing mode, a base address, a stride and a vector length. The generator then emits one address per element, together with the element number, the memory bank the address falls in and a last-element marker. Each element is offered on a valid/ready output port. In indexed mode, per-element offsets arrive on a separate valid/ready input stream. A fourth mode emits the arithmetic sequence 0, m, 2m, ... so that software can build an index vector without reading memory.

The memory behind the generator is interleaved across a power-of-two number of banks, chosen by the low word-address bits. Each access leaves its bank busy for a programmable number of cycles. When the next address targets a bank that is still busy, the generator holds that address and drops valid until the bank frees. Strides that alias onto one bank therefore throttle issue. Addresses always leave in element order. A fixed memory start-up delay separates the acceptance of a memory command from its first element.

Top module: `vag_addr_gen`

## Requirements
- R1: Mode code 0 (unit stride) gives element i the address base + 8*i, modulo 2^32.
- R2: Mode code 1 (constant stride) gives element i the address base + i*stride, where stride is in bytes and the sum wraps modulo 2^32.
- R3: Mode code 2 (indexed) gives element i the address base + the i-th word taken from the index stream, a byte offset that wraps modulo 2^32. One index word is consumed per element, in arrival order.
- R4: Mode code 3 (index ramp) puts i*stride on the address output for element i and ignores base. Ramp elements are never held for a busy bank and leave no bank busy.
- R5: A command with length L gives exactly min(L, 64) elements, numbered 0 upward. The last of them carries the last flag. A length of 0 produces no element.
- R6: In the three memory modes the first element is valid 12 cycles after the clock edge that accepts the command. In ramp mode it is valid 1 cycle after that edge. While the port is not stalled, each later element follows on the cycle after the previous one is taken.
- R7: The reported bank is address bits [6:3], the word address modulo 16.
- R8: After a memory-mode element is taken, its bank stays busy for lat-1 cycles, where lat is the busy-latency input. A latency of 0 or 1 never blocks. A pending memory-mode element whose bank is busy shows conflict high, shows valid low and keeps its address.
- R9: While valid is high and ready is low, the offered element and its address stay unchanged.
- R10: After reset, cmd_ready is 1 and out_valid and out_conflict are 0. cmd_ready is high only when no command is in progress and no element is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle and able to take a command |
| cmd_mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 ramp |
| cmd_base | input | 32 | Base byte address |
| cmd_stride | input | 32 | Byte stride (strided) or step m (ramp) |
| cmd_len | input | 7 | Vector length, capped at 64 |
| cfg_busy_lat | input | 4 | Bank busy latency in cycles |
| idx_valid | input | 1 | Index word offered |
| idx_ready | output | 1 | Index word taken this cycle |
| idx_data | input | 32 | Byte offset for the next indexed element |
| out_valid | output | 1 | Element address offered |
| out_ready | input | 1 | Consumer takes the element |
| out_addr | output | 32 | Element address or ramp value |
| out_elem | output | 7 | Element number |
| out_bank | output | 4 | Bank of out_addr |
| out_last | output | 1 | Final element of the command |
| out_conflict | output | 1 | Pending element blocked by a busy bank |

## Verification
A result becomes due 12 cycles after the edge that accepts a memory command, or 1 cycle after it for a ramp command. Each later element is due on the cycle after the previous one is taken, and is late by any cycles its bank remains busy. The bench keeps its own expected-element queue, a cycle counter and per-bank busy countdowns, all updated just before each rising edge. On every falling edge it compares valid, conflict, address, bank, element number, last flag and cmd_ready with the values those timings predict. Random back-pressure, strides that alias onto one bank, wrapping addresses and an over-long length exercise the stall and boundary cases.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_RAMP   = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WARM = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;
endpackage

// File: rtl/vag_ctrl.sv
// Sequencing: start-up wait, element counting, length cap.
module vag_ctrl
  import vag_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int VL_W    = 7,
  parameter int STARTUP = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_fire,
  input  logic            cmd_ramp,
  input  logic [VL_W-1:0] cmd_len,
  input  logic            adv,
  output logic            idle,
  output logic            run,
  output logic [VL_W-1:0] gen_idx,
  output logic            gen_last
);
  localparam int WC_W = $clog2(STARTUP + 1);
  localparam logic [VL_W-1:0] LEN_CAP   = VL_W'(MAX_VL);
  localparam logic [WC_W-1:0] WARM_INIT = WC_W'(STARTUP - 1);

  phase_e          phase;
  logic [WC_W-1:0] wcnt;
  logic [VL_W-1:0] len_q;
  logic [VL_W-1:0] len_eff;

  assign len_eff  = (cmd_len > LEN_CAP) ? LEN_CAP : cmd_len;
  assign idle     = (phase == PH_IDLE);
  assign run      = (phase == PH_RUN);
  assign gen_last = (gen_idx == len_q - VL_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      wcnt    <= '0;
      len_q   <= '0;
      gen_idx <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (cmd_fire) begin
            gen_idx <= '0;
            len_q   <= len_eff;
            wcnt    <= WARM_INIT;
            if (len_eff != '0) phase <= cmd_ramp ? PH_RUN : PH_WARM;
          end
        end
        PH_WARM: begin
          wcnt <= wcnt - WC_W'(1);
          if (wcnt <= WC_W'(1)) phase <= PH_RUN;
        end
        PH_RUN: begin
          if (adv) begin
            gen_idx <= gen_idx + VL_W'(1);
            if (gen_last) phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vag_addr_path.sv
// Address arithmetic: running accumulator for unit/strided/ramp, adder for indexed.
module vag_addr_path
  import vag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_fire,
  input  logic [1:0]        cmd_mode,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_stride,
  input  logic              adv,
  input  logic [ADDR_W-1:0] idx_data,
  output logic [ADDR_W-1:0] cand_addr,
  output logic              mode_index,
  output logic              mode_ramp
);
  localparam logic [ADDR_W-1:0] UNIT_STEP = ADDR_W'(ELEM_BYTES);

  amode_e            mode_q;
  amode_e            mode_in;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] step_q;
  logic [ADDR_W-1:0] acc_q;

  assign mode_in    = amode_e'(cmd_mode);
  assign mode_index = (mode_q == AM_INDEX);
  assign mode_ramp  = (mode_q == AM_RAMP);
  assign cand_addr  = mode_index ? (base_q + idx_data) : acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= AM_UNIT;
      base_q <= '0;
      step_q <= '0;
      acc_q  <= '0;
    end else if (cmd_fire) begin
      mode_q <= mode_in;
      base_q <= cmd_base;
      step_q <= (mode_in == AM_UNIT) ? UNIT_STEP : cmd_stride;
      acc_q  <= (mode_in == AM_RAMP) ? '0 : cmd_base;
    end else if (adv) begin
      acc_q  <= acc_q + step_q;
    end
  end
endmodule

// File: rtl/vag_bank_track.sv
// One busy countdown per interleaved bank.
module vag_bank_track #(
  parameter int NUM_BANKS = 16,
  parameter int LAT_W     = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mark,
  input  logic [BANK_W-1:0] mark_bank,
  input  logic [LAT_W-1:0]  lat,
  input  logic [BANK_W-1:0] probe_bank,
  output logic              probe_busy
);
  logic [NUM_BANKS-1:0] busy_vec;
  logic [LAT_W-1:0]     reload;

  assign reload = (lat == '0) ? '0 : lat - LAT_W'(1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [LAT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                                        cnt <= '0;
      else if (mark && (mark_bank == BANK_W'(b)))     cnt <= reload;
      else if (cnt != '0)                             cnt <= cnt - LAT_W'(1);
    end
    assign busy_vec[b] = (cnt != '0);
  end

  assign probe_busy = busy_vec[probe_bank];
endmodule

// File: rtl/vag_addr_gen.sv
module vag_addr_gen
  import vag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_VL     = 64,
  parameter int NUM_BANKS  = 16,
  parameter int ELEM_BYTES = 8,
  parameter int LAT_W      = 4,
  parameter int STARTUP    = 12,
  parameter int VL_W       = $clog2(MAX_VL + 1),
  parameter int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_mode,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_stride,
  input  logic [VL_W-1:0]   cmd_len,
  input  logic [LAT_W-1:0]  cfg_busy_lat,
  input  logic              idx_valid,
  output logic              idx_ready,
  input  logic [ADDR_W-1:0] idx_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [VL_W-1:0]   out_elem,
  output logic [BANK_W-1:0] out_bank,
  output logic              out_last,
  output logic              out_conflict
);
  localparam int BANK_LSB = $clog2(ELEM_BYTES);

  logic              cmd_fire, idle, run, gen_last, adv, room, fire;
  logic              cand_ok, mode_index, mode_ramp, bank_busy;
  logic [VL_W-1:0]   gen_idx;
  logic [ADDR_W-1:0] cand_addr;

  logic              hold_full, hold_chk, hold_last;
  logic [ADDR_W-1:0] hold_addr;
  logic [VL_W-1:0]   hold_elem;
  logic [BANK_W-1:0] hold_bank;

  assign cmd_ready = idle && !hold_full;
  assign cmd_fire  = cmd_valid && cmd_ready;

  vag_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W), .STARTUP(STARTUP)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire),
    .cmd_ramp(amode_e'(cmd_mode) == AM_RAMP), .cmd_len(cmd_len), .adv(adv),
    .idle(idle), .run(run), .gen_idx(gen_idx), .gen_last(gen_last)
  );

  vag_addr_path #(.ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES)) u_path (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .cmd_mode(cmd_mode),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .adv(adv), .idx_data(idx_data),
    .cand_addr(cand_addr), .mode_index(mode_index), .mode_ramp(mode_ramp)
  );

  vag_bank_track #(.NUM_BANKS(NUM_BANKS), .LAT_W(LAT_W), .BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst(rst), .mark(fire && hold_chk), .mark_bank(hold_bank),
    .lat(cfg_busy_lat), .probe_bank(hold_bank), .probe_busy(bank_busy)
  );

  assign out_conflict = hold_full && hold_chk && bank_busy;
  assign out_valid    = hold_full && !out_conflict;
  assign fire         = out_valid && out_ready;
  assign room         = !hold_full || fire;
  assign cand_ok      = run && (!mode_index || idx_valid);
  assign adv          = cand_ok && room;
  assign idx_ready    = run && mode_index && room;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_chk  <= 1'b0;
      hold_last <= 1'b0;
      hold_addr <= '0;
      hold_elem <= '0;
      hold_bank <= '0;
    end else if (adv) begin
      hold_full <= 1'b1;
      hold_chk  <= !mode_ramp;
      hold_last <= gen_last;
      hold_addr <= cand_addr;
      hold_elem <= gen_idx;
      hold_bank <= cand_addr[BANK_LSB +: BANK_W];
    end else if (fire) begin
      hold_full <= 1'b0;
    end
  end

  assign out_addr = hold_addr;
  assign out_elem = hold_elem;
  assign out_bank = hold_bank;
  assign out_last = hold_last;
endmodule

// File: rtl/vag_addr_gen_chk.sv
module vag_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int VL_W   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [VL_W-1:0]   out_elem,
  input logic              out_last,
  input logic              out_conflict
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_elem));

  // R8
  conflict_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_conflict));

  // R8
  conflict_holds_addr_chk: assert property (@(posedge clk) disable iff (rst)
    out_conflict |=> $stable(out_addr) && $stable(out_elem));

  // R10
  no_cmd_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !cmd_ready);

  // R6
  no_instant_elem_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !out_valid);

  // R5
  last_ends_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid);
endmodule

bind vag_addr_gen vag_addr_gen_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_elem(out_elem), .out_last(out_last), .out_conflict(out_conflict)
);

// File: tb/sim_vag_addr_gen.sv
module sim_vag_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_mode = 2'd0;
  logic [31:0] cmd_base = '0;
  logic [31:0] cmd_stride = '0;
  logic [6:0]  cmd_len = '0;
  logic [3:0]  cfg_busy_lat = 4'd4;
  logic        idx_valid = 1'b0;
  logic        idx_ready;
  logic [31:0] idx_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [6:0]  out_elem;
  logic [3:0]  out_bank;
  logic        out_last;
  logic        out_conflict;

  always #5 clk = ~clk;

  vag_addr_gen u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
    .cmd_len(cmd_len), .cfg_busy_lat(cfg_busy_lat), .idx_valid(idx_valid),
    .idx_ready(idx_ready), .idx_data(idx_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_elem(out_elem),
    .out_bank(out_bank), .out_last(out_last), .out_conflict(out_conflict)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit active = 0;
  bit rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference state
  logic [31:0] qa[$];
  int          qe[$];
  bit          ql[$];
  bit          qc[$];
  logic [31:0] iq[$];
  int  mbusy[16];
  int  ncyc = 0;
  int  first_cyc = 0;
  int  m_mode = 0;
  bit  pop_pend = 0;

  function automatic int bank_of(logic [31:0] a);
    return int'((a >> 3) & 32'd15);
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, ncyc);
    end
  endtask

  initial for (int b = 0; b < 16; b++) mbusy[b] = 0;

  always @(negedge clk) begin
    if (active) begin
      bit vis, conf, ev, fire, acc;
      int L;
      vis  = (qa.size() > 0) && (ncyc >= first_cyc);
      conf = vis && qc[0] && (mbusy[bank_of(qa[0])] > 0);
      ev   = vis && !conf;
      chk("R10", "cmd_ready", {31'd0, cmd_ready}, {31'd0, qa.size() == 0});
      chk("R6", "out_valid", {31'd0, out_valid}, {31'd0, ev});
      chk("R8", "out_conflict", {31'd0, out_conflict}, {31'd0, conf});
      if (ev) begin
        chk(mode_tag(m_mode), "out_addr", out_addr, qa[0]);
        chk("R7", "out_bank", {28'd0, out_bank}, bank_of(qa[0]));
        chk("R5", "out_elem", {25'd0, out_elem}, qe[0]);
        chk("R5", "out_last", {31'd0, out_last}, {31'd0, ql[0]});
      end
      if (pop_pend) void'(iq.pop_front());
      idx_valid = (iq.size() > 0);
      idx_data  = (iq.size() > 0) ? iq[0] : 32'd0;
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
      #2;
      // events of the coming rising edge
      ncyc++;
      fire     = ev && out_ready;
      pop_pend = idx_valid && idx_ready;
      acc      = cmd_valid && (qa.size() == 0);
      for (int b = 0; b < 16; b++) begin
        if (fire && qc[0] && b == bank_of(qa[0]))
          mbusy[b] = (cfg_busy_lat == 0) ? 0 : int'(cfg_busy_lat) - 1;
        else if (mbusy[b] > 0)
          mbusy[b]--;
      end
      if (fire) begin
        void'(qa.pop_front()); void'(qe.pop_front());
        void'(ql.pop_front()); void'(qc.pop_front());
      end
      if (acc) begin
        L = (cmd_len > 7'd64) ? 64 : int'(cmd_len);
        m_mode = int'(cmd_mode);
        first_cyc = ncyc + ((cmd_mode == 2'd3) ? 1 : 12);
        for (int i = 0; i < L; i++) begin
          logic [31:0] a;
          case (cmd_mode)
            2'd0: a = cmd_base + 32'(8 * i);
            2'd1: a = cmd_base + cmd_stride * 32'(i);
            2'd2: a = cmd_base + iq[i];
            default: a = cmd_stride * 32'(i);
          endcase
          qa.push_back(a); qe.push_back(i);
          ql.push_back(i == L - 1); qc.push_back(cmd_mode != 2'd3);
        end
      end
    end
  end

  task automatic send(logic [1:0] m, logic [31:0] base, logic [31:0] stride, int len);
    do @(negedge clk); while (!cmd_ready);
    cmd_valid  = 1'b1;
    cmd_mode   = m;
    cmd_base   = base;
    cmd_stride = stride;
    cmd_len    = 7'(len);
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic finish_cmd();
    do @(negedge clk); while (qa.size() != 0 || !cmd_ready);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R10", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10", "reset out_conflict", {31'd0, out_conflict}, 32'd0);
    active = 1;

    // R1 unit stride, free-running consumer
    send(2'd0, 32'h0000_1000, 32'd0, 5); finish_cmd();
    // R2 R8 stride of 32 words: every element in bank 0
    send(2'd1, 32'h0000_1000, 32'd256, 4); finish_cmd();
    // R2 R9 stride 3 words under back-pressure
    rdy_rand = 1;
    send(2'd1, 32'h0000_0040, 32'd24, 6); finish_cmd();
    // R3 indexed, offsets 0 and 128 share a bank
    iq.push_back(32'd0);   iq.push_back(32'd8);  iq.push_back(32'd128);
    iq.push_back(32'd136); iq.push_back(32'd16); iq.push_back(32'd128);
    send(2'd2, 32'h0000_2000, 32'd0, 6); finish_cmd();
    rdy_rand = 0;
    // R4 ramp with step 5, and a step that aliases one bank
    send(2'd3, 32'hDEAD_0000, 32'd5, 7); finish_cmd();
    send(2'd3, 32'h0000_1000, 32'd256, 3); finish_cmd();
    // R5 zero length produces nothing
    send(2'd0, 32'h0000_3000, 32'd0, 0); finish_cmd();
    // R8 latency 1 and 0 never block
    cfg_busy_lat = 4'd1;
    send(2'd1, 32'h0000_0000, 32'd128, 4); finish_cmd();
    cfg_busy_lat = 4'd0;
    send(2'd1, 32'h0000_0008, 32'd128, 4); finish_cmd();
    // R8 long latency with back-pressure
    cfg_busy_lat = 4'd7;
    rdy_rand = 1;
    send(2'd1, 32'h0000_0100, 32'd256, 3); finish_cmd();
    cfg_busy_lat = 4'd4;
    // R1 R2 address wrap
    send(2'd0, 32'hFFFF_FFF0, 32'd0, 4); finish_cmd();
    send(2'd1, 32'h0000_0010, 32'hFFFF_FFF8, 3); finish_cmd();
    // R5 length above the cap gives 64 elements
    send(2'd0, 32'h0000_4000, 32'd0, 100); finish_cmd();
    // back-to-back commands
    send(2'd1, 32'h0000_5000, 32'd16, 3);
    send(2'd3, 32'h0, 32'd3, 4); finish_cmd();

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog: actual run still busy, expected completion");
      summary();
      $finish;
    end
  end
endmodule